// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns parallel characters into asynchronous serial frames on a single output line. A host writes a character into a one-entry holding buffer. When the output shift register is free and transmission is enabled, the character moves into the shift register. The shift register then sends a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. Between frames the line rests high.

Each bit lasts 1, 16 or 64 cycles of the block clock, so the clock can run at one of those multiples of the baud rate. For example, a 153.6 kHz clock with the 16x setting gives 9600 baud. Two flags report the state of the two stages. The ready flag is high while the holding buffer can accept a character. The empty flag is high while the shift register is idle.

The character length (5 to 8 bits), the parity mode, the stop-bit count and the rate are all taken from configuration inputs. They are captured when a frame starts, so changing them during a frame does not affect that frame.

Top module: `astx_top`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), txReady, txEmpty and txLine are all 1.
- R2: A wrStrobe seen while txReady is 1 stores wrData, and txReady is 0 in the following cycle. A wrStrobe seen while txReady is 0 is ignored: the stored character is kept and no extra frame is sent.
- R3: If the shift register is idle and txEnable is 1, a stored character moves to the shift register at the next clock edge. At that edge txEmpty falls, txReady rises and txLine goes to 0 for the start bit.
- R4: A frame is sent as a 0 start bit followed by the data bits, bit 0 first. The number of data bits is 5 + charLen, where charLen is 0 to 3. Data bits above that length have no effect on the line.
- R5: When parityEn is 1, one parity bit follows the last data bit. With parityOdd = 0 it is the XOR of the sent data bits (even parity). With parityOdd = 1 it is that XOR inverted (odd parity). When parityEn is 0, no parity bit is sent.
- R6: The frame ends with stop bits at 1: one stop bit when twoStop = 0, two when twoStop = 1. After the last stop bit, txEmpty returns to 1 if no character is waiting.
- R7: Every bit of a frame lasts exactly N clock cycles. N is 1 for rateSel = 0, 16 for rateSel = 1, and 64 for rateSel = 2 or 3.
- R8: If a character is waiting and txEnable is 1 when the last stop bit ends, the next start bit begins in the very next cycle. txEmpty stays 0 across the boundary.
- R9: While txEnable is 0, no new frame starts: txLine stays 1, txEmpty stays 1 and a waiting character is held with txReady at 0. A frame already in progress when txEnable falls is completed unchanged.
- R10: Whenever txEmpty is 1, txLine is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, 1, 16 or 64 times the baud rate |
| rst | input | 1 | Synchronous reset, active high |
| txEnable | input | 1 | Allows new frames to start |
| charLen | input | 2 | Data bits per character minus 5 |
| parityEn | input | 1 | Adds a parity bit to the frame |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| twoStop | input | 1 | 1 selects two stop bits |
| rateSel | input | 2 | Clock cycles per bit: 0 for 1, 1 for 16, 2 or 3 for 64 |
| wrStrobe | input | 1 | Write strobe for the holding buffer |
| wrData | input | 8 | Character to send |
| txLine | output | 1 | Serial output line, high when idle |
| txReady | output | 1 | High while the holding buffer is empty |
| txEmpty | output | 1 | High while the shift register is idle |

## Verification
The bench sends single characters at every character length, with even parity, odd parity and no parity, and with one and two stop bits. Together these runs separate errors in bit order, length masking, parity polarity and stop-bit count. Each bit is sampled at both its first and its last cycle at all three rates, which exposes a divider that is one cycle off. A second character written during a frame, followed by a third written while the buffer is full, shows whether hand-over is back to back and whether writes to a full buffer are dropped. Holding txEnable low with a character waiting, and dropping it in the middle of a frame, shows the difference between blocking a new frame and cutting off a frame already running.

// File: rtl/astx_pkg.sv
package astx_pkg;
  localparam int DATA_MAX = 8;
  localparam int DATA_MIN = 5;
  localparam int FRAME_W  = 1 + DATA_MAX + 1 + 2;
  localparam int BITS_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic capture;
    logic load;
    logic shift;
  } txStrobe_t;
endpackage

// File: rtl/astx_ctrl.sv
module astx_ctrl
  import astx_pkg::*;
#(
  parameter int DIV_MID  = 16,
  parameter int DIV_HIGH = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       txEnable,
  input  logic       wrStrobe,
  input  logic [1:0] charLen,
  input  logic       parityEn,
  input  logic       twoStop,
  input  logic [1:0] rateSel,
  output txStrobe_t  strobe,
  output logic       txReady,
  output logic       txEmpty
);
  localparam int DIV_W = (DIV_HIGH > 1) ? $clog2(DIV_HIGH) : 1;

  logic              holdFull;
  logic              busy;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  divLast;
  logic [BITS_W-1:0] bitsLeft;
  logic [BITS_W-1:0] frameLen;
  logic [DIV_W-1:0]  divPick;
  logic              tick;
  logic              frameEnd;
  logic              startOk;

  // start, data, optional parity, one or two stops
  assign frameLen = BITS_W'(1 + DATA_MIN + 1) + BITS_W'(charLen)
                  + BITS_W'(parityEn) + BITS_W'(twoStop);

  always_comb begin
    unique case (rateSel)
      2'd0:    divPick = '0;
      2'd1:    divPick = DIV_W'(DIV_MID - 1);
      default: divPick = DIV_W'(DIV_HIGH - 1);
    endcase
  end

  assign tick     = busy && (divCnt == divLast);
  assign frameEnd = tick && (bitsLeft == BITS_W'(1));
  assign startOk  = holdFull && txEnable && (!busy || frameEnd);

  assign strobe.capture = wrStrobe && !holdFull;
  assign strobe.load    = startOk;
  assign strobe.shift   = tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdFull <= 1'b0;
      busy     <= 1'b0;
      divCnt   <= '0;
      divLast  <= '0;
      bitsLeft <= '0;
    end else begin
      if (strobe.capture)   holdFull <= 1'b1;
      else if (strobe.load) holdFull <= 1'b0;

      if (strobe.load) begin
        busy     <= 1'b1;
        divCnt   <= '0;
        divLast  <= divPick;
        bitsLeft <= frameLen;
      end else if (busy) begin
        if (tick) begin
          divCnt   <= '0;
          bitsLeft <= bitsLeft - BITS_W'(1);
          if (frameEnd) busy <= 1'b0;
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  assign txReady = !holdFull;
  assign txEmpty = !busy;

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!txEnable && !busy) |=> !busy);                                   // R9
  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (divCnt <= divLast));                                     // R7
  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
    (wrStrobe && txReady) |=> !txReady);                               // R2
endmodule

// File: rtl/astx_datapath.sv
module astx_datapath
  import astx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  txStrobe_t           strobe,
  input  logic [DATA_MAX-1:0] wrData,
  input  logic [1:0]          charLen,
  input  logic                parityEn,
  input  logic                parityOdd,
  output logic                txLine
);
  logic [DATA_MAX-1:0] holdReg;
  logic [FRAME_W-1:0]  shReg;
  logic [FRAME_W-1:0]  frameNext;
  logic                parBit;
  int                  dataLen;

  always_comb begin
    dataLen      = DATA_MIN + int'(charLen);
    frameNext    = '1;
    frameNext[0] = 1'b0;
    parBit       = parityOdd;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < dataLen) begin
        frameNext[1 + i] = holdReg[i];
        parBit           = parBit ^ holdReg[i];
      end
    end
    if (parityEn) frameNext[1 + dataLen] = parBit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdReg <= '0;
      shReg   <= '1;
    end else begin
      if (strobe.capture) holdReg <= wrData;
      if (strobe.load)        shReg <= frameNext;
      else if (strobe.shift)  shReg <= {1'b1, shReg[FRAME_W-1:1]};
    end
  end

  assign txLine = shReg[0];

  AST_LOAD_START_LOW: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> !txLine);                                          // R3
endmodule

// File: rtl/astx_top.sv
module astx_top
  import astx_pkg::*;
#(
  parameter int DIV_MID  = 16,
  parameter int DIV_HIGH = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       txEnable,
  input  logic [1:0] charLen,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       twoStop,
  input  logic [1:0] rateSel,
  input  logic       wrStrobe,
  input  logic [7:0] wrData,
  output logic       txLine,
  output logic       txReady,
  output logic       txEmpty
);
  txStrobe_t strobe;

  astx_ctrl #(.DIV_MID(DIV_MID), .DIV_HIGH(DIV_HIGH)) ctrl_i (
    .clk(clk), .rst(rst), .txEnable(txEnable), .wrStrobe(wrStrobe),
    .charLen(charLen), .parityEn(parityEn), .twoStop(twoStop),
    .rateSel(rateSel), .strobe(strobe), .txReady(txReady), .txEmpty(txEmpty)
  );

  astx_datapath dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wrData),
    .charLen(charLen), .parityEn(parityEn), .parityOdd(parityOdd),
    .txLine(txLine)
  );

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    txEmpty |-> txLine);                                               // R10
  AST_START_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    $fell(txEmpty) |-> (!txLine && txReady));                          // R3
endmodule

// File: tb/astx_top_tb_top.sv
`timescale 1ns/1ps
module astx_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       txEnable = 1'b1;
  logic [1:0] charLen = 2'd3;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       twoStop = 1'b0;
  logic [1:0] rateSel = 2'd0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       txLine, txReady, txEmpty;

  int nChecks = 0;
  int nFails  = 0;
  int curDiv  = 1;
  bit doneFlag = 1'b0;

  always #2.5 clk = ~clk;

  astx_top dut_i (
    .clk(clk), .rst(rst), .txEnable(txEnable), .charLen(charLen),
    .parityEn(parityEn), .parityOdd(parityOdd), .twoStop(twoStop),
    .rateSel(rateSel), .wrStrobe(wrStrobe), .wrData(wrData),
    .txLine(txLine), .txReady(txReady), .txEmpty(txEmpty)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int buildExp(input logic [7:0] d, input int len, input bit pe,
                                  input bit po, input bit ts, output logic [11:0] f);
    int n = 1;
    bit p = po;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < len; i++) begin
      f[n] = d[i];
      p = p ^ d[i];
      n++;
    end
    if (pe) begin f[n] = p; n++; end
    n++;
    if (ts) n++;
    return n;
  endfunction

  task automatic setCfg(input int len, input bit pe, input bit po, input bit ts, input int rs);
    charLen = 2'(len - 5); parityEn = pe; parityOdd = po; twoStop = ts;
    rateSel = 2'(rs);
    curDiv = (rs == 0) ? 1 : (rs == 1) ? 16 : 64;
  endtask

  // at a negedge: raise the strobe for one edge, return at the next negedge
  task automatic writeChar(input logic [7:0] d);
    wrStrobe = 1'b1; wrData = d;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  // called at the negedge where the start bit is first visible
  task automatic captureFrame(input int nBits, output logic [11:0] early, output logic [11:0] late);
    early = '1; late = '1;
    for (int i = 0; i < nBits; i++) begin
      early[i] = txLine;
      repeat (curDiv - 1) @(negedge clk);
      late[i] = txLine;
      @(negedge clk);
    end
  endtask

  task automatic sendOne(input string req, input logic [7:0] d, input int len,
                         input bit pe, input bit po, input bit ts, input int rs);
    logic [11:0] ef, e0, e1;
    int n;
    setCfg(len, pe, po, ts, rs);
    n = buildExp(d, len, pe, po, ts, ef);
    writeChar(d);
    check("R2", "ready after write", int'(txReady), 0);
    @(negedge clk);
    check("R3", "empty at transfer", int'(txEmpty), 0);
    check("R3", "ready at transfer", int'(txReady), 1);
    captureFrame(n, e0, e1);
    check(req, "frame first cycles", int'(e0), int'(ef));
    check("R7", "frame last cycles", int'(e1), int'(ef));
    check("R6", "empty after stops", int'(txEmpty), 1);
    check("R10", "line idle", int'(txLine), 1);
  endtask

  task automatic t_reset();
    check("R1", "ready", int'(txReady), 1);
    check("R1", "empty", int'(txEmpty), 1);
    check("R1", "line", int'(txLine), 1);
  endtask

  task automatic t_backToBack();
    logic [11:0] ef, e0, e1;
    int n;
    setCfg(8, 0, 0, 0, 1);
    n = buildExp(8'h3C, 8, 0, 0, 0, ef);
    writeChar(8'h3C);
    @(negedge clk);
    fork
      begin
        writeChar(8'hC3);      // accepted, buffer now full
        writeChar(8'h99);      // buffer full: dropped
        check("R2", "ready while full", int'(txReady), 0);
      end
    join_none
    captureFrame(n, e0, e1);
    check("R4", "first frame", int'(e0), int'(ef));
    check("R8", "no gap start", int'(txLine), 0);
    check("R8", "empty stays low", int'(txEmpty), 0);
    n = buildExp(8'hC3, 8, 0, 0, 0, ef);
    captureFrame(n, e0, e1);
    check("R8", "second frame", int'(e0), int'(ef));
    check("R2", "dropped write sends nothing", int'(txEmpty), 1);
    check("R2", "ready at end", int'(txReady), 1);
  endtask

  task automatic t_enable();
    logic [11:0] ef, e0, e1;
    int n;
    setCfg(7, 1, 1, 0, 0);
    n = buildExp(8'h5B, 7, 1, 1, 0, ef);
    txEnable = 1'b0;
    writeChar(8'h5B);
    repeat (20) @(negedge clk);
    check("R9", "line held high", int'(txLine), 1);
    check("R9", "empty held", int'(txEmpty), 1);
    check("R9", "char waiting", int'(txReady), 0);
    txEnable = 1'b1;
    @(negedge clk);
    check("R9", "start once enabled", int'(txLine), 0);
    captureFrame(n, e0, e1);
    check("R9", "frame after enable", int'(e0), int'(ef));
    // disable mid-frame: the frame must finish intact
    setCfg(8, 0, 0, 1, 1);
    n = buildExp(8'hB2, 8, 0, 0, 1, ef);
    writeChar(8'hB2);
    @(negedge clk);
    fork
      begin
        repeat (3 * 16) @(negedge clk);
        txEnable = 1'b0;
      end
    join_none
    captureFrame(n, e0, e1);
    check("R9", "frame completes", int'(e1), int'(ef));
    check("R9", "empty after cut", int'(txEmpty), 1);
    txEnable = 1'b1;
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    sendOne("R4", 8'h47, 8, 0, 0, 0, 0);
    sendOne("R4", 8'hF3, 5, 0, 0, 0, 1);
    sendOne("R6", 8'h49, 7, 0, 0, 1, 1);
    sendOne("R5", 8'h47, 8, 1, 0, 0, 0);
    sendOne("R5", 8'h2A, 6, 1, 1, 0, 0);
    sendOne("R7", 8'hA5, 8, 1, 0, 1, 2);
    sendOne("R7", 8'h5A, 5, 0, 0, 0, 3);
    t_backToBack();
    t_enable();
    finishRun();
  end
endmodule